// File: doc/BRIEF.md
# Character Display Write Port

This block is the write side of an eight-position dot-matrix character display controller. A host drives an asynchronous strobe bus: active-low select, write and flash strobes, a 4-bit address and a byte of data. The block brings those pins into the system clock and turns each write strobe into exactly one update of one of three stores. The first store is a character store with eight slots, each holding a 7-bit glyph code plus a font page bit. The second is a one-bit-per-position flash mask. The third is a single control byte.

The control byte doubles as a command. Setting its top bit starts a self-timed wipe. The wipe blanks every character slot and every flash bit, and it keeps them blank for a fixed number of clock cycles. During that window a later control write with the top bit low can end it early, but only after a minimum number of cycles has passed.

All stored contents leave the block on flat output buses for the scan logic, which also serve as the debug view. The write bus carries no flow control: strobes are plain pins, and the host is expected to respect the busy flag.

Top module: `dispreg_port`

## Requirements
- R1: A write is taken only when the synchronised write strobe falls while the select strobe is low. Strobing write with select high changes no store.
- R2: With the flash strobe low, a write copies data bit 0 into flash bit `addr[2:0]` of `flash_mask`, where bit n is position n. Address bit 3 and data bits 7..1 are ignored.
- R3: With the flash strobe high and address bit 3 low, the whole data byte is loaded into `ctrl_word`.
- R4: With the flash strobe high and address bit 3 high, the byte is stored in character slot `addr[2:0]`. Slot n sits at `char_slots[8n+7:8n]`, and slot 0 is the leftmost position. Bits 6..0 are the glyph code and bit 7 is the page select.
- R5: After reset, `ctrl_word` is 00h, `flash_mask` is 0, every slot holds 20h and `clear_busy` is low.
- R6: A control write with bit 7 set, made while no wipe runs, starts a wipe. It sets every slot to 20h and every flash bit to 0, and `ctrl_word` takes the written byte.
- R7: A wipe keeps `clear_busy` high for CLEAR_CYCLES clock cycles and then drops it.
- R8: While a wipe runs, a control write with bit 7 low ends it at once if at least MIN_ABORT_CYCLES cycles have passed since it began. Written sooner, such a control write, or any control write with bit 7 set, only updates `ctrl_word` and does not end or restart the wipe.
- R9: While `clear_busy` is high, character and flash writes are dropped, so the stores stay blank. Control writes are still accepted.
- R10: Each write strobe acts at most once, at its falling edge. A strobe that fell during a wipe and is still held low after the wipe ends writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Select strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_flash_n | input | 1 | Flash-mask select, active low |
| bus_addr | input | 4 | Bit 3 is the mode bit; bits 2..0 are the position |
| bus_data | input | 8 | Write data |
| clear_busy | output | 1 | High while a wipe runs |
| ctrl_word | output | 8 | Stored control byte |
| char_slots | output | 64 | Eight character slots; slot n is bits 8n+7..8n |
| flash_mask | output | 8 | Flash bit per position |

## Verification
The bench aims at the edges of the wipe window. It writes a bit-7-low control word soon after a wipe starts and checks that the wipe keeps running. A design that ignored the minimum delay would drop `clear_busy` early. It then writes the same kind of word past the minimum delay and expects the wipe to end at once; a design without early abort would stay busy for the full count. It attempts character and flash writes inside the wipe, and it holds one write strobe low across the end of the wipe. A level-sensitive or ungated write path would leave data in a slot that must read 20h. The flash test sets the mode bit and writes a byte with bit 0 clear. This catches a design that decodes the wrong data bit or routes the write by the mode bit.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;
  localparam int NPOS     = 8;
  localparam int POS_W    = $clog2(NPOS);
  localparam int ADDR_W   = POS_W + 1;
  localparam int BYTE_W   = 8;
  localparam int SLOTS_W  = NPOS * BYTE_W;
  localparam logic [BYTE_W-1:0] BLANK = 8'h20;
  localparam int WIPE_BIT = BYTE_W - 1;

  typedef enum logic [1:0] {OP_NONE, OP_FLASH, OP_CTRL, OP_CHAR} op_e;

  typedef struct packed {
    op_e               op;
    logic [POS_W-1:0]  pos;
    logic [BYTE_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/dispreg_sync.sv
module dispreg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dispreg_decode.sv
module dispreg_decode
  import dispreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              flash_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  output wr_cmd_t           cmd
);
  logic wr_prev;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_n;
  end

  assign fall = wr_prev & ~wr_n & ~cs_n;

  always_comb begin
    cmd.op   = OP_NONE;
    cmd.pos  = addr[POS_W-1:0];
    cmd.data = data;
    if (fall) begin
      if (!flash_n)          cmd.op = OP_FLASH;
      else if (addr[POS_W])  cmd.op = OP_CHAR;
      else                   cmd.op = OP_CTRL;
    end
  end
endmodule

// File: rtl/dispreg_clear_timer.sv
module dispreg_clear_timer #(
  parameter int CLEAR_CYCLES = 150,
  parameter int MIN_ABORT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop_req,
  output logic busy
);
  localparam int CW = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CW-1:0] LAST   = CW'(CLEAR_CYCLES - 1);
  localparam logic [CW-1:0] MIN_AB = CW'(MIN_ABORT_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (stop_req && cnt >= MIN_AB) begin
      busy <= 1'b0;
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dispreg_store.sv
module dispreg_store
  import dispreg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  wr_cmd_t            cmd,
  input  logic               busy,
  input  logic               wipe,
  output logic [SLOTS_W-1:0] chars,
  output logic [NPOS-1:0]    flash,
  output logic [BYTE_W-1:0]  ctrl
);
  generate
    for (genvar p = 0; p < NPOS; p++) begin : g_pos
      logic [BYTE_W-1:0] slot;
      logic              fbit;
      logic              hit;

      assign hit = !busy && (cmd.pos == POS_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          slot <= BLANK;
        else if (wipe)                       slot <= BLANK;
        else if (hit && cmd.op == OP_CHAR)   slot <= cmd.data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          fbit <= 1'b0;
        else if (wipe)                       fbit <= 1'b0;
        else if (hit && cmd.op == OP_FLASH)  fbit <= cmd.data[0];
      end

      assign chars[p*BYTE_W +: BYTE_W] = slot;
      assign flash[p] = fbit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl <= '0;
    else if (cmd.op == OP_CTRL) ctrl <= cmd.data;
  end
endmodule

// File: rtl/dispreg_port.sv
module dispreg_port
  import dispreg_pkg::*;
#(
  parameter int CLEAR_CYCLES = 150,
  parameter int MIN_ABORT_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs_n,
  input  logic               bus_wr_n,
  input  logic               bus_flash_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0]  bus_data,
  output logic               clear_busy,
  output logic [BYTE_W-1:0]  ctrl_word,
  output logic [SLOTS_W-1:0] char_slots,
  output logic [NPOS-1:0]    flash_mask
);
  localparam int BUS_W = 3 + ADDR_W + BYTE_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {(ADDR_W + BYTE_W){1'b0}}};

  logic [BUS_W-1:0]  bus_raw, bus_s;
  logic              cs_s, wr_s, fl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [BYTE_W-1:0] data_s;
  wr_cmd_t           cmd;
  logic              ctrl_wr, wipe_go, wipe_stop;

  assign bus_raw = {bus_cs_n, bus_wr_n, bus_flash_n, bus_addr, bus_data};

  dispreg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign {cs_s, wr_s, fl_s, addr_s, data_s} = bus_s;

  dispreg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_s), .wr_n(wr_s), .flash_n(fl_s),
    .addr(addr_s), .data(data_s), .cmd(cmd)
  );

  assign ctrl_wr   = (cmd.op == OP_CTRL);
  assign wipe_go   = ctrl_wr && cmd.data[WIPE_BIT] && !clear_busy;
  assign wipe_stop = ctrl_wr && !cmd.data[WIPE_BIT];

  dispreg_clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES), .MIN_ABORT_CYCLES(MIN_ABORT_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(wipe_go), .stop_req(wipe_stop), .busy(clear_busy)
  );

  dispreg_store u_store (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .busy(clear_busy), .wipe(wipe_go),
    .chars(char_slots), .flash(flash_mask), .ctrl(ctrl_word)
  );
endmodule

// File: rtl/dispreg_port_chk.sv
module dispreg_port_chk
  import dispreg_pkg::*;
#(
  parameter int CLEAR_CYCLES = 150
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear_busy,
  input logic               ctrl_wr,
  input logic [BYTE_W-1:0]  ctrl_word,
  input logic [SLOTS_W-1:0] char_slots,
  input logic [NPOS-1:0]    flash_mask
);
  localparam int RW = $clog2(CLEAR_CYCLES + 2);
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_cnt <= '0;
    else if (clear_busy) run_cnt <= run_cnt + 1'b1;
    else                 run_cnt <= '0;
  end

  // R3
  ctrl_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(ctrl_wr));

  // R6
  wipe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_busy |-> (flash_mask == '0 && char_slots == {NPOS{BLANK}}));

  // R7
  wipe_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_busy |-> run_cnt < RW'(CLEAR_CYCLES));

  // R2
  flash_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(clear_busy) |-> $countones(flash_mask ^ $past(flash_mask)) <= 1);

  // R9
  wipe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clear_busy) && clear_busy) |-> ($stable(char_slots) && $stable(flash_mask)));
endmodule

bind dispreg_port dispreg_port_chk #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_busy(clear_busy), .ctrl_wr(ctrl_wr),
  .ctrl_word(ctrl_word), .char_slots(char_slots), .flash_mask(flash_mask)
);

// File: tb/dispreg_port_bench.sv
module dispreg_port_bench;
  localparam int CLR   = 150;
  localparam int MINAB = 40;
  localparam logic [63:0] ALL_BLANK = {8{8'h20}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, fl_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  data = '0;
  logic        busy;
  logic [7:0]  ctrl;
  logic [63:0] slots;
  logic [7:0]  fmask;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int fall_cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dispreg_port #(.CLEAR_CYCLES(CLR), .MIN_ABORT_CYCLES(MINAB)) u_dispreg_port (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_flash_n(fl_n),
    .bus_addr(addr), .bus_data(data), .clear_busy(busy), .ctrl_word(ctrl),
    .char_slots(slots), .flash_mask(fmask)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic bus_write(logic f, logic [3:0] a, logic [7:0] d, logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; fl_n = f; addr = a; data = d;
    idle(2);
    wr_n = 1'b0; fall_cyc = cyc;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    cs_n = 1'b1; fl_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    check("R5 ctrl", 64'(ctrl), 64'h0);
    check("R5 flash", 64'(fmask), 64'h0);
    check("R5 slots", slots, ALL_BLANK);
    check("R5 busy", 64'(busy), 64'h0);
  endtask

  task automatic t_char();
    bus_write(1'b1, 4'b1000, 8'h41);
    bus_write(1'b1, 4'b1111, 8'hC1);
    check("R4 slot0", 64'(slots[7:0]), 64'h41);
    check("R4 slot7 page", 64'(slots[63:56]), 64'hC1);
    check("R4 others", 64'(slots[55:8]), 64'h202020202020);
  endtask

  task automatic t_ctrl();
    bus_write(1'b1, 4'b0011, 8'h5A);
    check("R3 ctrl", 64'(ctrl), 64'h5A);
    check("R3 slots kept", 64'(slots[7:0]), 64'h41);
  endtask

  task automatic t_flash();
    bus_write(1'b0, 4'b1011, 8'hFE);
    check("R2 bit0 only", 64'(fmask), 64'h00);
    bus_write(1'b0, 4'b1011, 8'h01);
    check("R2 set pos3", 64'(fmask), 64'h08);
    check("R2 char kept", 64'(slots[31:24]), 64'h20);
    bus_write(1'b0, 4'b0101, 8'h81);
    check("R2 set pos5", 64'(fmask), 64'h28);
    check("R2 ctrl kept", 64'(ctrl), 64'h5A);
  endtask

  task automatic t_select();
    bus_write(1'b1, 4'b1000, 8'h55, 1'b1);
    bus_write(1'b0, 4'b0000, 8'h01, 1'b1);
    bus_write(1'b1, 4'b0000, 8'h99, 1'b1);
    check("R1 slot", 64'(slots[7:0]), 64'h41);
    check("R1 flash", 64'(fmask), 64'h28);
    check("R1 ctrl", 64'(ctrl), 64'h5A);
  endtask

  task automatic t_wipe();
    int start;
    bus_write(1'b1, 4'b0000, 8'h9B);
    start = fall_cyc;
    check("R6 busy", 64'(busy), 64'h1);
    check("R6 slots", slots, ALL_BLANK);
    check("R6 flash", 64'(fmask), 64'h0);
    check("R6 ctrl", 64'(ctrl), 64'h9B);
    bus_write(1'b1, 4'b0000, 8'h13);
    check("R8 early stop ignored", 64'(busy), 64'h1);
    check("R9 ctrl taken", 64'(ctrl), 64'h13);
    bus_write(1'b1, 4'b1010, 8'h41);
    bus_write(1'b0, 4'b0010, 8'h01);
    check("R9 slot blocked", 64'(slots[23:16]), 64'h20);
    check("R9 flash blocked", 64'(fmask), 64'h0);
    wait_until(start + CLR - 20);
    check("R7 still busy", 64'(busy), 64'h1);
    wait_until(start + CLR + 20);
    check("R7 done", 64'(busy), 64'h0);
    bus_write(1'b1, 4'b1010, 8'h41);
    check("R9 write after wipe", 64'(slots[23:16]), 64'h41);
  endtask

  task automatic t_abort();
    int start;
    bus_write(1'b1, 4'b0000, 8'h80);
    start = fall_cyc;
    wait_until(start + MINAB + 20);
    check("R8 busy before stop", 64'(busy), 64'h1);
    bus_write(1'b1, 4'b0000, 8'h07);
    check("R8 stopped", 64'(busy), 64'h0);
    check("R8 ctrl", 64'(ctrl), 64'h07);
    bus_write(1'b1, 4'b1100, 8'h33);
    check("R8 write after stop", 64'(slots[39:32]), 64'h33);
  endtask

  task automatic t_held();
    int start;
    bus_write(1'b1, 4'b0000, 8'h80);
    start = fall_cyc;
    @(negedge clk);
    cs_n = 1'b0; fl_n = 1'b1; addr = 4'b1001; data = 8'h4B;
    idle(2);
    wr_n = 1'b0;
    wait_until(start + CLR + 20);
    check("R10 busy ended", 64'(busy), 64'h0);
    idle(5);
    check("R10 held strobe", 64'(slots[15:8]), 64'h20);
    wr_n = 1'b1;
    idle(4);
    cs_n = 1'b1;
    idle(4);
    check("R10 release", 64'(slots[15:8]), 64'h20);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_char();
    t_ctrl();
    t_flash();
    t_select();
    t_wipe();
    t_abort();
    t_held();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule